// File: doc/BRIEF.md
# Table-Driven TDMA Bus Arbiter

This block decides, cycle by cycle, which of several processors may drive a shared bus. The decision comes only from a schedule programmed in advance. A free-running time counter walks a period of programmable length. The period is split into segments. Each segment has its own start time, its own ordered list of owner positions, and either one slot length per position or one length shared by every position. Inside a segment the owner pattern repeats until the next segment begins. The whole schedule restarts when the period ends.

Requests never change the schedule. A processor is granted the bus only while the current slot is its own and it is requesting. A slot whose owner is idle stays unused, so each processor sees a bus access time that can be bounded without knowing what the others do. The table is loaded through a small write port while arbitration is disabled. The current owner index and the cycles left in the current slot are brought out so that the grant can be compared against a model of the schedule.

Top module: `tdma_table_arbiter`

## Requirements
- R1: While `arb_en` is low, every bit of `bus_gnt` is zero, and this is also the state after reset.
- R2: At most one grant bit is high in any cycle. `bus_gnt[i]` is high exactly when `arb_en` is high, `cur_owner` equals i, and `bus_req[i]` is high.
- R3: When the current slot owner is not requesting, all grants are zero, even if other processors are requesting.
- R4: The time counter runs from 0 to period-1 and then returns to 0. On that return the schedule restarts at segment 0, position 0.
- R5: Segment 0 begins at time 0. Segment s (1 ≤ s ≤ last segment index) begins, at its position 0, in the cycle the time counter equals that segment's start value. The last configured segment runs until the period ends.
- R6: In per-position mode (uniform bit 0), the positions of a segment are visited in order 0 up to the segment's last position, then again from 0. Each position lasts its own programmed size.
- R7: In uniform mode (uniform bit 1), every position of the segment lasts the segment's uniform size.
- R8: A slot that a segment start or the period end cuts short ends at once. The grant of the cut slot drops in the same cycle that the next slot's owner takes over.
- R9: Configuration writes made while `arb_en` is high have no effect on the schedule.
- R10: In the first cycle with `arb_en` high after it was low, the schedule is at time 0, segment 0, position 0, with no cycles of the slot elapsed.
- R11: `slot_left` equals the current slot's programmed length minus the cycles already spent in it, counted from 1 in the slot's last nominal cycle. It decrements by one each cycle inside a slot.
- R12: Write port encoding. The address is {kind[1:0], segment[2:0], position[1:0]}.
  - Kind 0, position 0: data[15:0] is the period.
  - Kind 0, position 1: data[2:0] is the last segment index.
  - Kind 1: data[15:0] is the segment start time.
  - Kind 2: data[15:0] is the uniform size, data[17:16] is the last position index, and data[18] is the uniform bit.
  - Kind 3: data[15:0] is the position size and data[17:16] is the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | Arbitration enable; low allows table writes and holds the schedule at its start |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address {kind, segment, position} |
| cfg_wdata | input | 19 | Configuration write data |
| bus_req | input | 4 | One request line per processor |
| bus_gnt | output | 4 | One grant line per processor, at most one high |
| cur_owner | output | 2 | Owner index of the current slot |
| slot_left | output | 16 | Cycles remaining in the current slot |

## Verification
The assertions check the following on every cycle: the one-hot-or-zero grant, the grant agreeing with the owner and its request, the silence of idle slots, the countdown of `slot_left` inside a slot, the return to the start at the period end and on enable, and the locking of the table while enabled. Whether the owners and slot lengths follow the programmed segments, and whether cut slots hand over at the right cycle, depend on the table contents. Only the bench's scenarios can show these, by comparing every cycle against an independent schedule model over a segmented table, a uniform-size segment and a list of single-slot segments.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  typedef enum logic [1:0] {
    CFG_GLOBAL    = 2'd0,
    CFG_SEG_START = 2'd1,
    CFG_SEG_CTRL  = 2'd2,
    CFG_POS       = 2'd3
  } cfg_kind_e;

  // A programmed length of zero behaves as a length of one.
  function automatic logic [31:0] nz_len(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table
  import tdma_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_SEG = 8,
  parameter int N_POS = 4,
  parameter int TW    = 16,
  localparam int IDXW = $clog2(N_CPU),
  localparam int SEGW = $clog2(N_SEG),
  localparam int POSW = $clog2(N_POS),
  localparam int FW   = (IDXW > POSW + 1) ? IDXW : POSW + 1,
  localparam int DW   = TW + FW,
  localparam int AW   = 2 + SEGW + POSW
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     arb_en,
  input  logic                                     cfg_we,
  input  logic [AW-1:0]                            cfg_addr,
  input  logic [DW-1:0]                            cfg_wdata,
  output logic [TW-1:0]                            period_o,
  output logic [SEGW-1:0]                          last_seg_o,
  output logic [N_SEG-1:0][TW-1:0]                 seg_start_o,
  output logic [N_SEG-1:0][POSW-1:0]               seg_last_pos_o,
  output logic [N_SEG-1:0]                         seg_uni_o,
  output logic [N_SEG-1:0][TW-1:0]                 seg_usize_o,
  output logic [N_SEG-1:0][N_POS-1:0][IDXW-1:0]    pos_owner_o,
  output logic [N_SEG-1:0][N_POS-1:0][TW-1:0]      pos_size_o
);

  cfg_kind_e        kind;
  logic [SEGW-1:0]  seg_a;
  logic [POSW-1:0]  pos_a;
  logic             wr_ok;

  assign kind  = cfg_kind_e'(cfg_addr[AW-1 -: 2]);
  assign seg_a = cfg_addr[POSW +: SEGW];
  assign pos_a = cfg_addr[0 +: POSW];
  assign wr_ok = cfg_we & ~arb_en;

  logic [TW-1:0]                          period_q;
  logic [SEGW-1:0]                        last_seg_q;
  logic [N_SEG-1:0][TW-1:0]               seg_start_q;
  logic [N_SEG-1:0][POSW-1:0]             seg_last_pos_q;
  logic [N_SEG-1:0]                       seg_uni_q;
  logic [N_SEG-1:0][TW-1:0]               seg_usize_q;
  logic [N_SEG-1:0][N_POS-1:0][IDXW-1:0]  pos_owner_q;
  logic [N_SEG-1:0][N_POS-1:0][TW-1:0]    pos_size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q       <= '0;
      last_seg_q     <= '0;
      seg_start_q    <= '0;
      seg_last_pos_q <= '0;
      seg_uni_q      <= '0;
      seg_usize_q    <= '0;
      pos_owner_q    <= '0;
      pos_size_q     <= '0;
    end else if (wr_ok) begin
      case (kind)
        CFG_GLOBAL: begin
          if (pos_a == POSW'(0))      period_q   <= cfg_wdata[TW-1:0];
          else if (pos_a == POSW'(1)) last_seg_q <= cfg_wdata[SEGW-1:0];
        end
        CFG_SEG_START: seg_start_q[seg_a] <= cfg_wdata[TW-1:0];
        CFG_SEG_CTRL: begin
          seg_usize_q[seg_a]    <= cfg_wdata[TW-1:0];
          seg_last_pos_q[seg_a] <= cfg_wdata[TW +: POSW];
          seg_uni_q[seg_a]      <= cfg_wdata[TW + POSW];
        end
        CFG_POS: begin
          pos_size_q[seg_a][pos_a]  <= cfg_wdata[TW-1:0];
          pos_owner_q[seg_a][pos_a] <= cfg_wdata[TW +: IDXW];
        end
        default: ;
      endcase
    end
  end

  assign period_o       = period_q;
  assign last_seg_o     = last_seg_q;
  assign seg_start_o    = seg_start_q;
  assign seg_last_pos_o = seg_last_pos_q;
  assign seg_uni_o      = seg_uni_q;
  assign seg_usize_o    = seg_usize_q;
  assign pos_owner_o    = pos_owner_q;
  assign pos_size_o     = pos_size_q;

  // R9: writes while arbitration runs leave the whole table unchanged
  p_table_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && arb_en) |=> ($stable(period_q) && $stable(last_seg_q) &&
                            $stable(seg_start_q) && $stable(seg_usize_q) &&
                            $stable(seg_uni_q) && $stable(seg_last_pos_q) &&
                            $stable(pos_size_q) && $stable(pos_owner_q)));

endmodule

// File: rtl/tdma_time_walker.sv
module tdma_time_walker
  import tdma_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_SEG = 8,
  parameter int N_POS = 4,
  parameter int TW    = 16,
  localparam int IDXW = $clog2(N_CPU),
  localparam int SEGW = $clog2(N_SEG),
  localparam int POSW = $clog2(N_POS)
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     arb_en,
  input  logic [TW-1:0]                            period_i,
  input  logic [SEGW-1:0]                          last_seg_i,
  input  logic [N_SEG-1:0][TW-1:0]                 seg_start_i,
  input  logic [N_SEG-1:0][POSW-1:0]               seg_last_pos_i,
  input  logic [N_SEG-1:0]                         seg_uni_i,
  input  logic [N_SEG-1:0][TW-1:0]                 seg_usize_i,
  input  logic [N_SEG-1:0][N_POS-1:0][IDXW-1:0]    pos_owner_i,
  input  logic [N_SEG-1:0][N_POS-1:0][TW-1:0]      pos_size_i,
  output logic [IDXW-1:0]                          owner_o,
  output logic [TW-1:0]                            rem_o
);

  logic [TW-1:0]   t_q;
  logic [SEGW-1:0] seg_q;
  logic [POSW-1:0] pos_q;
  logic [TW-1:0]   off_q;

  logic [SEGW-1:0] seg_nxt;
  logic [POSW-1:0] pos_nxt;
  logic [TW-1:0]   cur_len;
  logic [TW-1:0]   per_len;

  // Named internal events
  logic wrap_ev;
  logic seg_step_ev;
  logic slot_end_ev;

  function automatic logic [TW-1:0] slot_len(input logic uni,
                                             input logic [TW-1:0] usize,
                                             input logic [TW-1:0] psize);
    return TW'(nz_len(32'(uni ? usize : psize)));
  endfunction

  assign seg_nxt = seg_q + 1'b1;
  assign pos_nxt = (pos_q == seg_last_pos_i[seg_q]) ? '0 : pos_q + 1'b1;
  assign cur_len = slot_len(seg_uni_i[seg_q], seg_usize_i[seg_q],
                            pos_size_i[seg_q][pos_q]);
  assign per_len = TW'(nz_len(32'(period_i)));

  assign wrap_ev     = arb_en && (t_q == per_len - 1'b1);
  assign seg_step_ev = arb_en && !wrap_ev && (seg_q != last_seg_i) &&
                       (t_q + 1'b1 == seg_start_i[seg_nxt]);
  assign slot_end_ev = arb_en && !wrap_ev && !seg_step_ev &&
                       (off_q == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q   <= '0;
      seg_q <= '0;
      pos_q <= '0;
      off_q <= '0;
    end else if (!arb_en || wrap_ev) begin
      t_q   <= '0;
      seg_q <= '0;
      pos_q <= '0;
      off_q <= '0;
    end else if (seg_step_ev) begin
      t_q   <= t_q + 1'b1;
      seg_q <= seg_nxt;
      pos_q <= '0;
      off_q <= '0;
    end else if (slot_end_ev) begin
      t_q   <= t_q + 1'b1;
      pos_q <= pos_nxt;
      off_q <= '0;
    end else begin
      t_q   <= t_q + 1'b1;
      off_q <= off_q + 1'b1;
    end
  end

  assign owner_o = pos_owner_i[seg_q][pos_q];
  assign rem_o   = cur_len - off_q;

  // R10: first enabled cycle sits at the very start of the schedule
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_en) |-> (t_q == '0 && seg_q == '0 && pos_q == '0 && off_q == '0));

  // R4: the period end returns to time 0, segment 0, position 0
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (t_q == '0 && seg_q == '0 && pos_q == '0));

  // R5: a new segment always opens at its first position
  p_seg_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_step_ev |=> (pos_q == '0 && off_q == '0 && seg_q == $past(seg_nxt)));

  // R11: remaining count stays inside the slot and counts down
  p_rem_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en |-> (rem_o != '0 && rem_o <= cur_len));

  p_rem_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !wrap_ev && !seg_step_ev && !slot_end_ev) |=>
      (!arb_en || rem_o == $past(rem_o) - 1'b1));

endmodule

// File: rtl/tdma_grant_gate.sv
module tdma_grant_gate #(
  parameter int N_CPU = 4,
  localparam int IDXW = $clog2(N_CPU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_en,
  input  logic [N_CPU-1:0] bus_req,
  input  logic [IDXW-1:0]  owner,
  output logic [N_CPU-1:0] bus_gnt
);

  for (genvar i = 0; i < N_CPU; i++) begin : g_gnt
    assign bus_gnt[i] = arb_en & bus_req[i] & (owner == IDXW'(i));
  end

  // R2: never more than one grant
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  // R2: any grant belongs to the requesting slot owner
  p_owner_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_gnt) |-> (bus_req[owner] && bus_gnt[owner]));

  // R2: a requesting owner in an enabled cycle is served
  p_serve_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && bus_req[owner]) |-> bus_gnt[owner]);

  // R3: idle slot is not handed to anyone
  p_idle_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !bus_req[owner]) |-> (bus_gnt == '0));

  // R1: no grant while disabled
  p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> (bus_gnt == '0));

endmodule

// File: rtl/tdma_table_arbiter.sv
module tdma_table_arbiter
  import tdma_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_SEG = 8,
  parameter int N_POS = 4,
  parameter int TW    = 16,
  localparam int IDXW = $clog2(N_CPU),
  localparam int SEGW = $clog2(N_SEG),
  localparam int POSW = $clog2(N_POS),
  localparam int FW   = (IDXW > POSW + 1) ? IDXW : POSW + 1,
  localparam int DW   = TW + FW,
  localparam int AW   = 2 + SEGW + POSW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_en,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [N_CPU-1:0] bus_req,
  output logic [N_CPU-1:0] bus_gnt,
  output logic [IDXW-1:0]  cur_owner,
  output logic [TW-1:0]    slot_left
);

  logic [TW-1:0]                          period;
  logic [SEGW-1:0]                        last_seg;
  logic [N_SEG-1:0][TW-1:0]               seg_start;
  logic [N_SEG-1:0][POSW-1:0]             seg_last_pos;
  logic [N_SEG-1:0]                       seg_uni;
  logic [N_SEG-1:0][TW-1:0]               seg_usize;
  logic [N_SEG-1:0][N_POS-1:0][IDXW-1:0]  pos_owner;
  logic [N_SEG-1:0][N_POS-1:0][TW-1:0]    pos_size;

  tdma_sched_table #(.N_CPU(N_CPU), .N_SEG(N_SEG), .N_POS(N_POS), .TW(TW)) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .arb_en         (arb_en),
    .cfg_we         (cfg_we),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .period_o       (period),
    .last_seg_o     (last_seg),
    .seg_start_o    (seg_start),
    .seg_last_pos_o (seg_last_pos),
    .seg_uni_o      (seg_uni),
    .seg_usize_o    (seg_usize),
    .pos_owner_o    (pos_owner),
    .pos_size_o     (pos_size)
  );

  tdma_time_walker #(.N_CPU(N_CPU), .N_SEG(N_SEG), .N_POS(N_POS), .TW(TW)) u_walker (
    .clk            (clk),
    .rst_n          (rst_n),
    .arb_en         (arb_en),
    .period_i       (period),
    .last_seg_i     (last_seg),
    .seg_start_i    (seg_start),
    .seg_last_pos_i (seg_last_pos),
    .seg_uni_i      (seg_uni),
    .seg_usize_i    (seg_usize),
    .pos_owner_i    (pos_owner),
    .pos_size_i     (pos_size),
    .owner_o        (cur_owner),
    .rem_o          (slot_left)
  );

  tdma_grant_gate #(.N_CPU(N_CPU)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .arb_en  (arb_en),
    .bus_req (bus_req),
    .owner   (cur_owner),
    .bus_gnt (bus_gnt)
  );

  // R8: on a slot change the previous owner's grant is already gone
  p_handover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && $past(arb_en) && cur_owner != $past(cur_owner)) |->
      !bus_gnt[$past(cur_owner)]);

endmodule

// File: tb/tdma_table_arbiter_bench.sv
`timescale 1ns/1ps
module tdma_table_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arb_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic [3:0]  bus_req = '0;
  logic [3:0]  bus_gnt;
  logic [1:0]  cur_owner;
  logic [15:0] slot_left;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  // Model of the programmed schedule
  int m_period;
  int m_last_seg;
  int m_start   [8];
  int m_lastpos [8];
  int m_uni     [8];
  int m_usize   [8];
  int m_own     [8][4];
  int m_size    [8][4];

  localparam logic [3:0] REQ_TAB [16] = '{4'hF, 4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'hD, 4'hB,
                                          4'h6, 4'h9, 4'hE, 4'h7, 4'h3, 4'hC, 4'h5, 4'hA};

  always #2.5 clk = ~clk;

  tdma_table_arbiter u_tdma_table_arbiter (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cur_owner(cur_owner), .slot_left(slot_left)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R12: address {kind, segment, position}
  task automatic cfg_write(input int kind, input int seg, input int pos, input logic [18:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {2'(kind), 3'(seg), 2'(pos)};
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic set_period(input int p);
    cfg_write(0, 0, 0, 19'(p));
    m_period = p;
  endtask

  task automatic set_last_seg(input int s);
    cfg_write(0, 0, 1, 19'(s));
    m_last_seg = s;
  endtask

  task automatic set_seg(input int s, input int start, input int lastpos, input int uni, input int usize);
    cfg_write(1, s, 0, 19'(start));
    cfg_write(2, s, 0, {1'(uni), 2'(lastpos), 16'(usize)});
    m_start[s] = start; m_lastpos[s] = lastpos; m_uni[s] = uni; m_usize[s] = usize;
  endtask

  task automatic set_pos(input int s, input int p, input int own, input int size);
    cfg_write(3, s, p, {1'b0, 2'(own), 16'(size)});
    m_own[s][p] = own; m_size[s][p] = size;
  endtask

  task automatic model(input int t, output int own, output int rem, output int sg);
    int s, beg, off, p, len;
    s = 0; beg = 0; p = 0; len = 1;
    for (int k = 1; k <= m_last_seg; k++)
      if (t >= m_start[k]) begin s = k; beg = m_start[k]; end
    off = t - beg;
    while (1) begin
      len = (m_uni[s] != 0) ? m_usize[s] : m_size[s][p];
      if (len == 0) len = 1;
      if (off < len) break;
      off -= len;
      p = (p == m_lastpos[s]) ? 0 : p + 1;
    end
    own = m_own[s][p]; rem = len - off; sg = s;
  endtask

  task automatic check_cycle(input int t, input string otag);
    int own, rem, sg, eg;
    model(t, own, rem, sg);
    eg = bus_req[own] ? (1 << own) : 0;
    chk(otag, "owner", int'(cur_owner), own);
    chk("R11", "slot_left", int'(slot_left), rem);
    chk(bus_req[own] ? "R2" : "R3", "grant", int'(bus_gnt), eg);
  endtask

  initial begin
    m_period = 0; m_last_seg = 0;
    for (int s = 0; s < 8; s++) begin
      m_start[s] = 0; m_lastpos[s] = 0; m_uni[s] = 0; m_usize[s] = 0;
      for (int p = 0; p < 4; p++) begin m_own[s][p] = 0; m_size[s][p] = 0; end
    end

    // R1: reset state, disabled
    bus_req = 4'hF;
    repeat (3) @(negedge clk);
    #1 chk("R1", "grant in reset", int'(bus_gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1", "grant after reset", int'(bus_gnt), 0);

    // Segmented table: per-position, uniform, per-position
    set_period(64);
    set_last_seg(2);
    set_seg(0, 0, 1, 0, 0);
    set_pos(0, 0, 1, 12);
    set_pos(0, 1, 2, 13);
    set_seg(1, 30, 2, 1, 3);
    set_pos(1, 0, 2, 0);
    set_pos(1, 1, 0, 0);
    set_pos(1, 2, 3, 0);
    set_seg(2, 45, 1, 0, 0);
    set_pos(2, 0, 2, 7);
    set_pos(2, 1, 1, 25);

    arb_en = 1'b1;
    for (int c = 0; c < 128; c++) begin
      string tag;
      int t;
      t = c % 64;
      bus_req = REQ_TAB[c % 16];
      // R9: writes attempted while enabled
      if (c == 3) begin cfg_we = 1'b1; cfg_addr = {2'd0, 3'd0, 2'd0}; cfg_wdata = 19'd5; end
      if (c == 4) begin cfg_addr = {2'd1, 3'd1, 2'd0}; cfg_wdata = 19'd20; end
      if (c == 5) cfg_we = 1'b0;
      tag = (t >= 30 && t < 45) ? "R7" : "R6";
      if (t == 30 || t == 45) tag = "R5";
      if (c == 64) tag = "R4";
      if (c == 21 || c == 10) tag = "R9";
      #1 check_cycle(t, tag);
      @(negedge clk);
    end

    // R8: slot cut by segment start at t=30
    bus_req = 4'hF;
    repeat (29) @(negedge clk);
    #1 chk("R8", "grant before cut", int'(bus_gnt), 4'b0010);
    @(negedge clk);
    #1 chk("R8", "grant after cut", int'(bus_gnt), 4'b0100);
    chk("R7", "slot_left uniform", int'(slot_left), 3);

    // R1 / R10: disable then re-enable mid-period
    @(negedge clk);
    arb_en = 1'b0;
    #1 chk("R1", "grant while disabled", int'(bus_gnt), 0);
    repeat (3) @(negedge clk);
    arb_en = 1'b1;
    bus_req = 4'b1101;
    #1 chk("R10", "owner on restart", int'(cur_owner), 1);
    chk("R10", "slot_left on restart", int'(slot_left), 12);
    chk("R3", "idle owner grant", int'(bus_gnt), 0);

    // Slot-list form: single-position segments at 0,8,16,24,32,42, period 52
    @(negedge clk);
    arb_en = 1'b0;
    set_period(52);
    set_last_seg(5);
    begin
      int starts [6] = '{0, 8, 16, 24, 32, 42};
      int owners [6] = '{1, 2, 1, 2, 2, 1};
      for (int s = 0; s < 6; s++) begin
        set_seg(s, starts[s], 0, 0, 0);
        set_pos(s, 0, owners[s], 60);
      end
    end
    arb_en = 1'b1;
    for (int c = 0; c < 60; c++) begin
      bus_req = (c % 5 == 4) ? 4'h9 : 4'hF;
      #1 check_cycle(c % 52, (c == 52) ? "R4" : "R5");
      @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule